// File: doc/BRIEF.md
# Clock Source Control and Status Register

This block is the software-visible heart of a clock control unit. One 8-bit register holds the bits that pick the system clock source. These are a divide-by-16 select, a PLL select and a stop-enable for the crystal oscillator. The same register also holds read-only status: the reset cause, PLL lock and whether the alternate clock is active. Software writes it through a plain synchronous port, and the current image is always visible on the read bus.

Several bits change without software. The reset-cause flags come up with a value that depends on why the chip was reset. A stop-enable request written by software stays invisible until the alternate clock is running. Hardware clears the PLL select whenever the PLL cannot be trusted. From the register contents the block derives a 2-bit effective source code, a PLL enable, an oscillator stop request and a one-cycle interrupt whenever the divide-by-16 bit changes. The clock multiplexer, the PLL and the oscillator lie outside the block and appear only as status inputs.

Reset is asynchronous and active-low. Its release is synchronised internally. For the first cycles after release the register loads its cause-dependent image, and writes during that time are ignored.

Top module: `clksrc_ctl`

## Requirements
- R1: After reset the register reads 0x48 when `rst_cause` is 2'b01 (watchdog), 0x28 when it is 2'b10 (software), and 0x08 for 2'b00 or 2'b11 (power-on).
- R2: Bit 7 (external-stop flag) is set the cycle after `ext_stop_evt` is high. It clears only when a write has bit 7 at 0. An event in the same cycle as such a write leaves it set.
- R3: Bits 6 and 5 (watchdog and software reset flags), bit 2 (alternate-clock status) and bit 1 (lock) are not changed by any write.
- R4: A write with bit 4 at 1 does not make bit 4 (stop-enable) read 1 while bit 2 reads 0. Bit 4 becomes 1 the cycle after bit 2 reads 1, whether bit 2 was already 1 at the write or becomes 1 later.
- R5: A write with bit 4 at 0 clears bit 4 and cancels any pending stop-enable request, so a later rise of bit 2 does not set bit 4.
- R6: `osc_stop_req` is high exactly when bit 4 and bit 2 both read 1.
- R7: Bit 3 (divide-by-16 select, 1 = undivided) is written by software. `div_irq` is high for the single cycle after each change of bit 3, and `pll_en` equals bit 3.
- R8: Bit 0 (PLL select) takes the written value, except that it is forced to 0 in the next cycle, even over a write of 1, when `pll_div_cfg` is all ones, when `osc_stopped` is high, when `wfi_evt` and `lp_wait_en` are both high, or when bit 3 changes from 1 to 0.
- R9: Bit 2 reads 1 the cycle after `alt_clk_req` and `alt_clk_present` are both high, and 0 otherwise.
- R10: `clk_src_sel` is 2'b11 when bit 2 is 1. Otherwise it is 2'b00 when bit 3 is 0. Otherwise it is 2'b10 when bits 0 and 1 are both 1, and 2'b01 in every remaining case.
- R11: While bit 1 reads 0, `clk_src_sel` never shows 2'b10, even with bit 0 at 1.
- R12: Bit 1 reads 1 the cycle after `pll_lock` is high while `pll_en` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_cause | input | 2 | Cause of the current reset, held steady through reset release |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register image |
| ext_stop_evt | input | 1 | External stop event |
| pll_lock | input | 1 | PLL lock indication |
| alt_clk_req | input | 1 | Request to run from the alternate clock |
| alt_clk_present | input | 1 | A clock is seen on the alternate clock input |
| pll_div_cfg | input | 3 | PLL divider configuration code; all ones turns the PLL off |
| lp_wait_en | input | 1 | Low-power wait-for-interrupt mode enabled |
| wfi_evt | input | 1 | Wait-for-interrupt entry |
| osc_stopped | input | 1 | Crystal oscillator is stopped |
| clk_src_sel | output | 2 | Effective source: 00 crystal/16, 01 crystal, 10 PLL, 11 alternate |
| pll_en | output | 1 | PLL enable |
| osc_stop_req | output | 1 | Request to stop the crystal oscillator |
| div_irq | output | 1 | One-cycle pulse on a change of the divide-by-16 bit |

## Verification
Every cycle, the assertions check the following. The alternate clock wins the source code, and an unlocked PLL is never reported. Stop-enable only rises after alternate-clock status. The PLL select stays clear after a disabling divider code or a stopped oscillator, and a write of 0 to stop-enable always takes effect. They also check that the reset flags stay steady, that the interrupt matches a change of the divide bit, and that the external-stop flag follows its event. The bench scenarios are needed for the rest. These are the cause-dependent reset images, a pending stop request surviving many cycles and then landing or being cancelled, and the hardware clear beating a simultaneous software write. They also cover random interleavings of writes with status changes, compared against a cycle model.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  localparam int unsigned REG_W = 8;

  // bit positions within the register image
  localparam int unsigned B_EXT  = 7;
  localparam int unsigned B_WDG  = 6;
  localparam int unsigned B_SW   = 5;
  localparam int unsigned B_STOP = 4;
  localparam int unsigned B_DIV  = 3;
  localparam int unsigned B_ALT  = 2;
  localparam int unsigned B_LOCK = 1;
  localparam int unsigned B_PSEL = 0;

  typedef enum logic [1:0] {
    CAUSE_POR   = 2'b00,
    CAUSE_WDG   = 2'b01,
    CAUSE_SW    = 2'b10,
    CAUSE_OTHER = 2'b11
  } rst_cause_e;

  typedef enum logic [1:0] {
    SRC_XT_DIV = 2'b00,
    SRC_XT     = 2'b01,
    SRC_PLL    = 2'b10,
    SRC_ALT    = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic wdg;
    logic sw;
  } cause_flags_t;

  function automatic cause_flags_t cause_decode(input logic [1:0] cause);
    cause_flags_t f;
    f.wdg = (cause == CAUSE_WDG);
    f.sw  = (cause == CAUSE_SW);
    return f;
  endfunction

endpackage

// File: rtl/clksrc_rst_sync.sv
module clksrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/clksrc_flags.sv
module clksrc_flags
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_ok,
  input  logic [1:0] rst_cause,
  input  logic       wr_en,
  input  logic       wr_ext,
  input  logic       wr_stop,
  input  logic       ext_stop_evt,
  input  logic       alt_st,
  output logic       ext_q,
  output logic       wdg_q,
  output logic       sw_q,
  output logic       stop_en_q
);
  cause_flags_t cause_f;
  logic ext_d, wdg_d, sw_d, stop_en_d, pend_d, pend_q, armed;

  assign cause_f = cause_decode(rst_cause);

  always_comb begin
    ext_d     = ext_q;
    wdg_d     = wdg_q;
    sw_d      = sw_q;
    stop_en_d = stop_en_q;
    pend_d    = pend_q;
    armed     = 1'b0;
    if (!rst_ok) begin
      ext_d     = 1'b0;
      wdg_d     = cause_f.wdg;
      sw_d      = cause_f.sw;
      stop_en_d = 1'b0;
      pend_d    = 1'b0;
    end else begin
      // external stop: event has priority over a software clear
      if (ext_stop_evt)          ext_d = 1'b1;
      else if (wr_en && !wr_ext) ext_d = 1'b0;
      // deferred stop-enable
      armed     = wr_en ? wr_stop : (pend_q | stop_en_q);
      stop_en_d = armed & (stop_en_q | alt_st);
      pend_d    = armed & ~stop_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      wdg_q     <= 1'b0;
      sw_q      <= 1'b0;
      stop_en_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      ext_q     <= ext_d;
      wdg_q     <= wdg_d;
      sw_q      <= sw_d;
      stop_en_q <= stop_en_d;
      pend_q    <= pend_d;
    end
  end

  assert_extstop_set_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    ext_stop_evt |=> ext_q);

  assert_cause_steady_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> ($stable(wdg_q) && $stable(sw_q)));

  assert_stop_waits_alt_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(stop_en_q) |-> $past(alt_st));

  assert_stop_cancel_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && !wr_stop) |=> !stop_en_q);
endmodule

// File: rtl/clksrc_select.sv
module clksrc_select
  import clksrc_pkg::*;
#(
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_ok,
  input  logic             wr_en,
  input  logic             wr_div,
  input  logic             wr_psel,
  input  logic             pll_lock,
  input  logic             alt_clk_req,
  input  logic             alt_clk_present,
  input  logic [CFG_W-1:0] pll_div_cfg,
  input  logic             osc_stopped,
  input  logic             wfi_evt,
  input  logic             lp_wait_en,
  output logic             div_q,
  output logic             alt_q,
  output logic             lock_q,
  output logic             psel_q,
  output logic             irq_q,
  output logic [1:0]       src_sel,
  output logic             pll_en
);
  localparam logic [CFG_W-1:0] CFG_OFF = {CFG_W{1'b1}};

  logic div_d, alt_d, lock_d, psel_d, irq_d, div_fall, hw_clr;
  clk_src_e src;

  always_comb begin
    div_d  = div_q;
    alt_d  = alt_q;
    lock_d = lock_q;
    psel_d = psel_q;
    irq_d  = 1'b0;
    div_fall = 1'b0;
    hw_clr   = 1'b0;
    if (!rst_ok) begin
      div_d  = 1'b1;
      alt_d  = 1'b0;
      lock_d = 1'b0;
      psel_d = 1'b0;
    end else begin
      if (wr_en) div_d = wr_div;
      irq_d    = div_d ^ div_q;
      div_fall = div_q & ~div_d;
      alt_d    = alt_clk_req & alt_clk_present;
      lock_d   = pll_lock & div_q;
      hw_clr   = (pll_div_cfg == CFG_OFF) | osc_stopped |
                 (wfi_evt & lp_wait_en) | div_fall;
      if (hw_clr)     psel_d = 1'b0;
      else if (wr_en) psel_d = wr_psel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b1;
      alt_q  <= 1'b0;
      lock_q <= 1'b0;
      psel_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      alt_q  <= alt_d;
      lock_q <= lock_d;
      psel_q <= psel_d;
      irq_q  <= irq_d;
    end
  end

  // source priority: alternate, then divided crystal, then locked PLL
  always_comb begin
    if (alt_q)                src = SRC_ALT;
    else if (!div_q)          src = SRC_XT_DIV;
    else if (psel_q && lock_q) src = SRC_PLL;
    else                      src = SRC_XT;
  end

  assign src_sel = src;
  assign pll_en  = div_q;

  assert_irq_on_change_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_q |-> (div_q != $past(div_q)));

  assert_cfg_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (pll_div_cfg == CFG_OFF) |=> !psel_q);

  assert_osc_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    osc_stopped |=> !psel_q);

  assert_alt_wins_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    alt_q |-> (src_sel == 2'b11));

  assert_no_unlocked_pll_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    !lock_q |-> (src_sel != 2'b10));
endmodule

// File: rtl/clksrc_ctl.sv
module clksrc_ctl
  import clksrc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rst_cause,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             ext_stop_evt,
  input  logic             pll_lock,
  input  logic             alt_clk_req,
  input  logic             alt_clk_present,
  input  logic [CFG_W-1:0] pll_div_cfg,
  input  logic             lp_wait_en,
  input  logic             wfi_evt,
  input  logic             osc_stopped,
  output logic [1:0]       clk_src_sel,
  output logic             pll_en,
  output logic             osc_stop_req,
  output logic             div_irq
);
  logic rst_ok;
  logic ext_q, wdg_q, sw_q, stop_en_q;
  logic div_q, alt_q, lock_q, psel_q;
  logic unused_ro;

  assign unused_ro = ^{wr_data[B_WDG], wr_data[B_SW], wr_data[B_ALT], wr_data[B_LOCK]};

  clksrc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  clksrc_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_ok       (rst_ok),
    .rst_cause    (rst_cause),
    .wr_en        (wr_en),
    .wr_ext       (wr_data[B_EXT]),
    .wr_stop      (wr_data[B_STOP]),
    .ext_stop_evt (ext_stop_evt),
    .alt_st       (alt_q),
    .ext_q        (ext_q),
    .wdg_q        (wdg_q),
    .sw_q         (sw_q),
    .stop_en_q    (stop_en_q)
  );

  clksrc_select #(.CFG_W(CFG_W)) u_sel (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_ok          (rst_ok),
    .wr_en           (wr_en),
    .wr_div          (wr_data[B_DIV]),
    .wr_psel         (wr_data[B_PSEL]),
    .pll_lock        (pll_lock),
    .alt_clk_req     (alt_clk_req),
    .alt_clk_present (alt_clk_present),
    .pll_div_cfg     (pll_div_cfg),
    .osc_stopped     (osc_stopped),
    .wfi_evt         (wfi_evt),
    .lp_wait_en      (lp_wait_en),
    .div_q           (div_q),
    .alt_q           (alt_q),
    .lock_q          (lock_q),
    .psel_q          (psel_q),
    .irq_q           (div_irq),
    .src_sel         (clk_src_sel),
    .pll_en          (pll_en)
  );

  assign rd_data      = {ext_q, wdg_q, sw_q, stop_en_q, div_q, alt_q, lock_q, psel_q};
  assign osc_stop_req = stop_en_q & alt_q;

  assert_osc_req_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    osc_stop_req |-> (rd_data[B_STOP] && rd_data[B_ALT]));

  assert_pll_en_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    pll_en == rd_data[B_DIV]);
endmodule

// File: tb/clksrc_ctl_bench.sv
`timescale 1ns/1ps
module clksrc_ctl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] rst_cause;
  logic wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic ext_stop_evt, pll_lock, alt_clk_req, alt_clk_present;
  logic [2:0] pll_div_cfg;
  logic lp_wait_en, wfi_evt, osc_stopped;
  logic [1:0] clk_src_sel;
  logic pll_en, osc_stop_req, div_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic m_ext, m_wdg, m_sw, m_sen, m_pend, m_div, m_alt, m_lock, m_psel, m_irq;

  always #2 clk = ~clk;

  clksrc_ctl u_clksrc_ctl (
    .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_stop_evt(ext_stop_evt), .pll_lock(pll_lock),
    .alt_clk_req(alt_clk_req), .alt_clk_present(alt_clk_present),
    .pll_div_cfg(pll_div_cfg), .lp_wait_en(lp_wait_en), .wfi_evt(wfi_evt),
    .osc_stopped(osc_stopped), .clk_src_sel(clk_src_sel), .pll_en(pll_en),
    .osc_stop_req(osc_stop_req), .div_irq(div_irq)
  );

  function automatic logic [7:0] exp_image();
    return {m_ext, m_wdg, m_sw, m_sen, m_div, m_alt, m_lock, m_psel};
  endfunction

  function automatic logic [1:0] exp_src();
    if (m_alt)              return 2'b11;
    else if (!m_div)        return 2'b00;
    else if (m_psel && m_lock) return 2'b10;
    else                    return 2'b01;
  endfunction

  function automatic logic [7:0] reset_image(input logic [1:0] c);
    case (c)
      2'b01:   return 8'h48;
      2'b10:   return 8'h28;
      default: return 8'h08;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_data = 0; ext_stop_evt = 0; pll_lock = 0; alt_clk_req = 0;
    alt_clk_present = 0; pll_div_cfg = 0; lp_wait_en = 0; wfi_evt = 0; osc_stopped = 0;
  endtask

  // advance one clock with the currently driven inputs, updating the model
  task automatic step();
    logic armed, n_sen, n_div, hwclr;
    armed = wr_en ? wr_data[4] : (m_pend | m_sen);
    n_sen = armed & (m_sen | m_alt);
    n_div = wr_en ? wr_data[3] : m_div;
    hwclr = (pll_div_cfg == 3'b111) | osc_stopped | (wfi_evt & lp_wait_en) | (m_div & ~n_div);
    @(posedge clk);
    m_ext  = ext_stop_evt | (m_ext & ~(wr_en & ~wr_data[7]));
    m_pend = armed & ~n_sen;
    m_sen  = n_sen;
    m_irq  = n_div ^ m_div;
    m_lock = pll_lock & m_div;
    m_div  = n_div;
    m_alt  = alt_clk_req & alt_clk_present;
    m_psel = hwclr ? 1'b0 : (wr_en ? wr_data[0] : m_psel);
    @(negedge clk);
  endtask

  task automatic check_all();
    chk("R2 ext flag", {7'd0, rd_data[7]}, {7'd0, m_ext});
    chk("R3 ro bits", {4'd0, rd_data[6], rd_data[5], rd_data[2], rd_data[1]},
        {4'd0, m_wdg, m_sw, m_alt, m_lock});
    chk("R4 stop-enable", {7'd0, rd_data[4]}, {7'd0, m_sen});
    chk("R6 osc stop req", {7'd0, osc_stop_req}, {7'd0, m_sen & m_alt});
    chk("R7 div/irq/pll_en", {5'd0, rd_data[3], div_irq, pll_en}, {5'd0, m_div, m_irq, m_div});
    chk("R8 pll select", {7'd0, rd_data[0]}, {7'd0, m_psel});
    chk("R10 source code", {6'd0, clk_src_sel}, {6'd0, exp_src()});
  endtask

  task automatic do_reset(input logic [1:0] c);
    quiet();
    rst_cause = c;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    {m_ext, m_wdg, m_sw, m_sen, m_div, m_alt, m_lock, m_psel} = reset_image(c);
    m_pend = 0; m_irq = 0;
    chk("R1 reset image", rd_data, reset_image(c));
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    quiet();
    // R1: each reset cause
    do_reset(2'b01);
    do_reset(2'b10);
    do_reset(2'b11);
    do_reset(2'b00);

    // R3: writes to read-only bits have no effect
    wr(8'h66); check_all();
    chk("R3 ro after write", {rd_data[6], rd_data[5], rd_data[2], rd_data[1], 4'd0}, 8'h00);

    // R11: PLL selected but unlocked reports crystal
    wr(8'h09); check_all();
    chk("R11 unlocked pll", {6'd0, clk_src_sel}, 8'h01);
    pll_lock = 1; step(); step(); check_all();
    chk("R12 lock shown", {7'd0, rd_data[1]}, 8'h01);
    chk("R10 pll source", {6'd0, clk_src_sel}, 8'h02);

    // R8: hardware clear wins over a simultaneous write of 1
    pll_div_cfg = 3'b111; wr(8'h09); pll_div_cfg = 0; check_all();
    chk("R8 clear beats write", {7'd0, rd_data[0]}, 8'h00);
    wr(8'h09); check_all();
    // R8/R7: dropping divide bit clears select and pulses irq
    wr(8'h01); check_all();
    chk("R8 div fall clear", {7'd0, rd_data[0]}, 8'h00);
    chk("R7 irq pulse", {7'd0, div_irq}, 8'h01);
    step(); check_all();
    chk("R7 irq single", {7'd0, div_irq}, 8'h00);
    wr(8'h08); check_all();

    // R4: deferred stop-enable
    wr(8'h18); check_all();
    repeat (5) begin step(); check_all(); end
    chk("R4 still hidden", {7'd0, rd_data[4]}, 8'h00);
    alt_clk_req = 1; alt_clk_present = 1; step(); check_all();
    chk("R9 alt status", {7'd0, rd_data[2]}, 8'h01);
    step(); check_all();
    chk("R4 lands after alt", {7'd0, rd_data[4]}, 8'h01);
    chk("R6 stop request", {7'd0, osc_stop_req}, 8'h01);

    // R5: cancel pending request
    wr(8'h08); alt_clk_req = 0; step(); step(); check_all();
    wr(8'h18); step(); check_all();
    wr(8'h08); alt_clk_req = 1; step(); step(); step(); check_all();
    chk("R5 cancel holds", {7'd0, rd_data[4]}, 8'h00);

    // R9: request without clock present does not take effect
    alt_clk_present = 0; step(); check_all();
    chk("R9 no clock no select", {7'd0, rd_data[2]}, 8'h00);

    // R2: external stop set, event beats clear
    ext_stop_evt = 1; wr(8'h08); ext_stop_evt = 0; check_all();
    chk("R2 event wins", {7'd0, rd_data[7]}, 8'h01);
    wr(8'h08); check_all();
    chk("R2 cleared", {7'd0, rd_data[7]}, 8'h00);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr_en           = ($urandom % 4) == 0;
      wr_data         = 8'($urandom);
      ext_stop_evt    = ($urandom % 20) == 0;
      if (($urandom % 8) == 0) pll_lock = ~pll_lock;
      if (($urandom % 6) == 0) alt_clk_req = ~alt_clk_req;
      alt_clk_present = ($urandom % 4) != 0;
      pll_div_cfg     = (($urandom % 10) == 0) ? 3'b111 : 3'($urandom % 7);
      lp_wait_en      = $urandom % 2;
      wfi_evt         = ($urandom % 10) == 0;
      osc_stopped     = ($urandom % 25) == 0;
      step();
      check_all();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule